// File: doc/BRIEF.md
# Chained Serial Input Scanner Controller

This controller reads a chain of external 8-bit parallel-in, serial-out input expanders through three wires. The wires are an active-low load strobe (`ld_n`), a shift clock (`sclk`) and a single serial return line (`sdi`). Each expander in the chain feeds its serial output into the serial input of the next one. The controller reads only the output of the device nearest to it. A start request makes the controller pulse the load strobe, which freezes every parallel input of every device at the same moment. It then walks the chain bit by bit and presents the assembled word together with a one-cycle `done` flag.

The serial line already carries the highest-order bit once the load pulse ends, so every bit is sampled before its shift edge. After each sample the controller raises the shift clock and drops it again. A scan therefore takes exactly as many samples and rising edges as the chain holds bits. The returning data passes through a two-flop synchroniser. It is sampled in the last system clock of each clock-low phase, so the synchronised value has settled by then.

The parameters are the number of devices and the number of system clocks per phase. A load-low, clock-high or clock-low phase each lasts that many clocks, which keeps the external shift rate well inside the device limit. The controller has five states. IDLE moves to LOAD on `start`. LOAD moves to LOW when its phase ends. LOW samples the serial line and moves to HIGH when its phase ends. HIGH moves back to LOW when its phase ends while bits remain, or to DONE after the final bit. DONE returns to IDLE after one cycle.

Top module: `piso_scan_ctrl`

## Requirements
- R1: Out of reset, and whenever no scan is running, `ld_n` is 1, `sclk` is 0 and `done` is 0; a reset in mid-scan returns to this state at once.
- R2: A `start` seen while idle drives `ld_n` to 0 for exactly PHASE_CYC clocks, with `sclk` held at 0 during that time.
- R3: Bits are assembled MSB-first: the bit present on `sdi` right after the load pulse, before any `sclk` rising edge, ends up in `word[W-1]`, and the k-th later bit ends up in `word[W-1-k]`, where W = 8*NUM_DEV.
- R4: One scan issues exactly 8*NUM_DEV rising edges on `sclk` (16 for the default of two devices).
- R5: Every `sclk` high phase lasts PHASE_CYC clocks, and every low phase that comes before a rising edge (the one after the load, and the ones between pulses) also lasts PHASE_CYC clocks.
- R6: `done` is a pulse exactly one clock long that follows the final clock fall. `word` changes only at that pulse, and it keeps its value until the next pulse.
- R7: A `start` that arrives while a scan is running is ignored: it causes no second load pulse and no extra `done`.
- R8: The result is the value the parallel inputs held during the load pulse; input changes after `ld_n` returns high have no effect on `word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Scan request, accepted only while idle |
| sdi | input | 1 | Serial data returned by the last device in the chain |
| ld_n | output | 1 | Active-low parallel load strobe to every device |
| sclk | output | 1 | Shift clock to every device |
| word | output | 8*NUM_DEV | Assembled input word, MSB-first |
| done | output | 1 | One-cycle flag marking a new `word` |

## Verification
The assertions watch the strobe and clock on every cycle. They check that the load and clock never overlap, and that the load width, each high width and the number of rising edges per scan match the parameters. They also check that `done` is a single cycle that comes only after one load and the full edge count, and that no second load starts before `done`. Only the bench scenarios can show that the bit order is correct and that inputs are captured at load time. The bench runs a model chain, changes its inputs after the load, and compares the resulting word against the loaded pattern. It also issues stray start requests and a mid-scan reset.

// File: rtl/piso_scan_pkg.sv
package piso_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_LOW  = 3'd2,
        ST_HIGH = 3'd3,
        ST_DONE = 3'd4
    } scan_state_t;
endpackage

// File: rtl/pscan_sync.sv
module pscan_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff <= '0;
        end else begin
            ff[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                ff[i] <= ff[i-1];
            end
        end
    end

    assign dout = ff[STAGES-1];
endmodule

// File: rtl/pscan_timer.sv
module pscan_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic phase_end
);
    localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    logic [CW-1:0] cnt;

    assign phase_end = active && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || phase_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pscan_shreg.sv
module pscan_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[W-2:0], din};
        end
    end
endmodule

// File: rtl/piso_scan_ctrl.sv
module piso_scan_ctrl
    import piso_scan_pkg::*;
#(
    parameter int NUM_DEV      = 2,
    parameter int BITS_PER_DEV = 8,
    parameter int PHASE_CYC    = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            sdi,
    output logic                            ld_n,
    output logic                            sclk,
    output logic [NUM_DEV*BITS_PER_DEV-1:0] word,
    output logic                            done
);
    localparam int TOTAL = NUM_DEV * BITS_PER_DEV;
    localparam int BCW   = $clog2(TOTAL + 1);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(TOTAL);

    scan_state_t state, state_nx;
    logic [BCW-1:0] bit_cnt;
    logic           phase_end;
    logic           timer_run;
    logic           sdi_sync;
    logic           sample_en;
    logic [TOTAL-1:0] assembled;

    assign timer_run = (state == ST_LOAD) || (state == ST_LOW) || (state == ST_HIGH);
    assign sample_en = (state == ST_LOW) && phase_end;

    pscan_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sdi),
        .dout  (sdi_sync)
    );

    pscan_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (timer_run),
        .phase_end (phase_end)
    );

    pscan_shreg #(.W(TOTAL)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_en),
        .din      (sdi_sync),
        .q        (assembled)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)     state_nx = ST_LOAD;
            ST_LOAD: if (phase_end) state_nx = ST_LOW;
            ST_LOW:  if (phase_end) state_nx = ST_HIGH;
            ST_HIGH: if (phase_end) state_nx = (bit_cnt == BIT_LAST) ? ST_DONE : ST_LOW;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) begin
                bit_cnt <= '0;
            end else if (sample_en) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // registered outputs, aligned with the state they belong to
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_n <= 1'b1;
            sclk <= 1'b0;
            done <= 1'b0;
            word <= '0;
        end else begin
            ld_n <= (state_nx != ST_LOAD);
            sclk <= (state_nx == ST_HIGH);
            done <= (state_nx == ST_DONE);
            if (state_nx == ST_DONE) begin
                word <= assembled;
            end
        end
    end
endmodule

// File: rtl/pscan_chk.sv
module pscan_chk #(
    parameter int TOTAL     = 16,
    parameter int PHASE_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ld_n,
    input logic sclk,
    input logic done
);
    int   low_run;
    int   high_run;
    int   edges;
    int   loads_open;
    logic sclk_d;
    logic ld_n_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run    <= 0;
            high_run   <= 0;
            edges      <= 0;
            loads_open <= 0;
            sclk_d     <= 1'b0;
            ld_n_d     <= 1'b1;
        end else begin
            sclk_d   <= sclk;
            ld_n_d   <= ld_n;
            low_run  <= ld_n ? 0 : low_run + 1;
            high_run <= sclk ? high_run + 1 : 0;
            if (!ld_n)
                edges <= 0;
            else if (sclk && !sclk_d)
                edges <= edges + 1;
            if (done)
                loads_open <= 0;
            else if (!ld_n && ld_n_d)
                loads_open <= loads_open + 1;
        end
    end

    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |-> !sclk);

    a_r1_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ld_n && !sclk));

    a_r2_load_width: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !ld_n_d) |-> (low_run == PHASE_CYC));

    a_r5_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && sclk_d) |-> (high_run == PHASE_CYC));

    a_r4_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (edges == TOTAL));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && ld_n_d) |-> (loads_open == 0));

    a_r7_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (loads_open == 1));
endmodule

bind piso_scan_ctrl pscan_chk #(
    .TOTAL     (NUM_DEV * BITS_PER_DEV),
    .PHASE_CYC (PHASE_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_n  (ld_n),
    .sclk  (sclk),
    .done  (done)
);

// File: tb/piso_scan_ctrl_test.sv
`timescale 1ns/1ps
module piso_scan_ctrl_test;
    localparam int ND = 2;
    localparam int W  = 8 * ND;
    localparam int P  = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sdi;
    logic         ld_n, sclk, done;
    logic [W-1:0] word;
    logic [W-1:0] par = '0;
    logic [W-1:0] chain = '0;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    piso_scan_ctrl #(.NUM_DEV(ND), .BITS_PER_DEV(8), .PHASE_CYC(P)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .sdi   (sdi),
        .ld_n  (ld_n),
        .sclk  (sclk),
        .word  (word),
        .done  (done)
    );

    // model chain: upper byte belongs to the device next to the controller,
    // first device's serial input is tied low
    always @(posedge sclk or negedge ld_n) begin
        if (!ld_n) chain <= par;
        else       chain <= {chain[W-2:0], 1'b0};
    end
    assign sdi = chain[W-1];

    localparam logic [W-1:0] VEC [0:5] = '{
        16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'hA55A, 16'h3C96
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic run_scan(input logic [W-1:0] v, input bit flip, input bit extra);
        int low_len = 0, loads = 0, rises = 0, hi_len = 0, lo_len = 0;
        int bad_hi = 0, bad_lo = 0, overlap = 0, cyc = 0;
        logic prev_ld = 1'b1, prev_sclk = 1'b0;
        bit got_done = 0;
        par = v;
        @(negedge clk) start = 1'b1;
        while (!got_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (extra && cyc == 20) start = 1'b1;
            if (extra && cyc == 21) start = 1'b0;
            if (!ld_n) begin
                low_len++;
                if (prev_ld) loads++;
                if (sclk) overlap++;
            end
            if (ld_n && !prev_ld && flip) par = ~par;
            if (sclk) begin
                hi_len++;
                if (!prev_sclk) begin
                    rises++;
                    if (lo_len != P) bad_lo++;
                end
                lo_len = 0;
            end else begin
                if (prev_sclk) begin
                    if (hi_len != P) bad_hi++;
                    hi_len = 0;
                end
                if (ld_n && loads > 0) lo_len++;
            end
            prev_ld = ld_n;
            prev_sclk = sclk;
            if (done) got_done = 1;
        end
        chk(got_done, "R6", "done seen", W'(got_done), W'(1));
        chk(word == v, flip ? "R8" : "R3", "word", word, v);
        chk(rises == W, "R4", "rising edges", W'(rises), W'(W));
        chk(low_len == P, "R2", "load width", W'(low_len), W'(P));
        chk(overlap == 0, "R2", "clock during load", W'(overlap), W'(0));
        chk(bad_hi == 0 && bad_lo == 0, "R5", "phase widths",
            W'(bad_hi + bad_lo), W'(0));
        chk(loads == 1, "R7", "load pulses", W'(loads), W'(1));
        @(negedge clk);
        chk(!done, "R6", "done width", W'(done), W'(0));
        chk(word == v, "R6", "word held", word, v);
        chk(ld_n && !sclk, "R1", "idle levels", {ld_n, sclk}, 2'b10);
        if (extra) begin
            int stray = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (!ld_n || done) stray++;
            end
            chk(stray == 0, "R7", "no second scan", W'(stray), W'(0));
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ld_n == 1'b1, "R1", "ld_n in reset", W'(ld_n), W'(1));
        chk(sclk == 1'b0, "R1", "sclk in reset", W'(sclk), W'(0));
        chk(done == 1'b0 && word == '0, "R1", "done/word in reset", word, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ld_n && !sclk && !done, "R1", "idle after reset",
            {ld_n, sclk, done}, 3'b100);

        for (int i = 0; i < 6; i++) run_scan(VEC[i], 1'b0, 1'b0);

        for (int i = 0; i < 3; i++) run_scan(W'($urandom), 1'b0, 1'b0);

        // R8: inputs flipped after the load pulse
        run_scan(16'hC3A1, 1'b1, 1'b0);
        // R7: stray start in mid-scan
        run_scan(16'h5E17, 1'b0, 1'b1);

        // R1: reset in mid-scan
        par = 16'h1111;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (15) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ld_n && !sclk && !done, "R1", "mid-scan reset levels",
            {ld_n, sclk, done}, 3'b100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_scan(16'h9D2B, 1'b0, 1'b0);

        finish_run();
    end
endmodule